// File: doc/BRIEF.md
# Write-Recovery Clamp and AGC Hold Controller

This block drives two control lines for a read front end around write operations. One closes a low-impedance clamp across the amplifier inputs. The other freezes the automatic gain control. The write-gate input may change at any moment and has no setup or hold window. The block passes it through a two-stage synchronizer and then applies a polarity chosen by a configuration bit. While the synchronized gate is active, both outputs stay asserted.

When the write ends, the clamp and the AGC hold both stay asserted for one of two release delays and then drop together. The delays are counted in reference-clock cycles, and the long delay is twice the short one. If the gate becomes active again before the delay runs out, the countdown is abandoned and the outputs never drop. The analog switch and the AGC loop themselves lie outside this block.

Top module: `wrClampHold`

## Requirements
- R1: With `invertPol` = 0 the write gate is active when `writeGateIn` is 1. With `invertPol` = 1 it is active when `writeGateIn` is 0.
- R2: Suppose `writeGateIn` changes to its active level between two rising edges. Then `clampOn` is first seen high after the third rising edge that follows the change, and it stays high while the gate remains active.
- R3: Suppose the gate is active for L rising edges and then goes inactive. Then `clampOn` is high for exactly L + D consecutive cycles, where D is the release delay.
- R4: D is `SHORT_CYCLES` when `slowSel` = 0 and 2 × `SHORT_CYCLES` when `slowSel` = 1.
- R5: `slowSel` is taken in the last cycle of the write. A change of `slowSel` during the release delay leaves the length of that delay unchanged.
- R6: Suppose the gate becomes active again during the release delay. Then `clampOn` stays high with no gap, and a full new delay D follows the final end of the write.
- R7: `agcHold` equals `clampOn` in every cycle.
- R8: During reset both outputs are 0. After reset they stay 0 while the gate line sits at its inactive level, for either polarity.
- R9: A gate pulse that spans a single rising edge still counts as a write with L = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| writeGateIn | input | 1 | Raw write gate. It is asynchronous to `clk`. |
| invertPol | input | 1 | Gate polarity select (1: the gate is active low) |
| slowSel | input | 1 | Release delay select (1: long delay) |
| clampOn | output | 1 | Low-impedance clamp enable |
| agcHold | output | 1 | AGC hold |

## Verification
The bench sweeps single write pulses of one to six cycles over both polarities and both delay selects. The pulse length separates synchronizer latency from the release count. The select bit separates the short delay from the long one. The polarity sweep shows that the inverted level, not the raw level, starts a write. Re-entry patterns put a second write at several points inside the release window and show that the countdown is abandoned with no gap. A late change of the delay select shows that the delay is fixed when the write ends. Idle lines held through reset at either polarity show that the synchronizer's power-up contents cause no spurious clamp.

// File: rtl/clampPkg.sv
package clampPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_RELEASE = 2'd2
  } clampState_t;

  // strobes from the control FSM to the delay datapath
  typedef struct packed {
    logic load;     // reload the release counter
    logic dec;      // count one release cycle
    logic useLong;  // pick the doubled delay on reload
  } dlyStrobe_t;

endpackage

// File: rtl/clampDelay.sv
module clampDelay
  import clampPkg::*;
#(
  parameter int SHORT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dlyStrobe_t stb,
  output logic       done
);

  localparam int LONG_CYCLES = 2 * SHORT_CYCLES;
  localparam int CW = $clog2(LONG_CYCLES);
  localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.load) begin
      cnt <= stb.useLong ? LONG_LOAD : SHORT_LOAD;
    end else if (stb.dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // R3
  decrement_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dec && !stb.load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R4
  done_after_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(stb.dec));

endmodule

// File: rtl/clampCtrl.sv
module clampCtrl
  import clampPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       writeGateIn,
  input  logic       invertPol,
  input  logic       slowSel,
  input  logic       done,
  output dlyStrobe_t stb,
  output logic       clampOn,
  output logic       agcHold
);

  logic        syncQ1, syncQ2;
  logic [1:0]  primeCnt;
  logic        primed;
  logic        act;
  clampState_t state, stateNext;

  // two-stage synchronizer for the asynchronous gate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= 1'b0;
      syncQ2 <= 1'b0;
    end else begin
      syncQ1 <= writeGateIn;
      syncQ2 <= syncQ1;
    end
  end

  // ignore the synchronizer until it holds sampled data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primeCnt <= 2'd0;
    else if (!primed) primeCnt <= primeCnt + 2'd1;
  end

  assign primed = (primeCnt == 2'd2);
  assign act    = primed && (syncQ2 ^ invertPol);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (act) stateNext = ST_WRITE;
      ST_WRITE:   if (!act) stateNext = ST_RELEASE;
      ST_RELEASE: begin
        if (act) stateNext = ST_WRITE;
        else if (done) stateNext = ST_IDLE;
      end
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    stb.load    = (state == ST_WRITE);
    stb.dec     = (state == ST_RELEASE);
    stb.useLong = slowSel;
  end

  assign clampOn = (state != ST_IDLE);
  assign agcHold = (state != ST_IDLE);

  // R2
  write_holds_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    act |=> clampOn);

  // R6
  release_only_counting_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clampOn) |-> ($past(stb.dec) && !$past(act)));

endmodule

// File: rtl/wrClampHold.sv
module wrClampHold
  import clampPkg::*;
#(
  parameter int SHORT_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic writeGateIn,
  input  logic invertPol,
  input  logic slowSel,
  output logic clampOn,
  output logic agcHold
);

  dlyStrobe_t stb;
  logic       done;

  clampCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .writeGateIn (writeGateIn),
    .invertPol   (invertPol),
    .slowSel     (slowSel),
    .done        (done),
    .stb         (stb),
    .clampOn     (clampOn),
    .agcHold     (agcHold)
  );

  clampDelay #(.SHORT_CYCLES(SHORT_CYCLES)) uDelay (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .done (done)
  );

endmodule

// File: tb/tb_wrClampHold.sv
`timescale 1ns/1ps
module tb_wrClampHold;

  localparam int SHORT = 5;
  localparam int LONG  = 2 * SHORT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic writeGateIn = 1'b0;
  logic invertPol = 1'b0;
  logic slowSel = 1'b0;
  logic clampOn, agcHold;

  int nChecks = 0;
  int nFails = 0;
  int idx, hi, first, last, agcBad;

  wrClampHold #(.SHORT_CYCLES(SHORT)) dut (
    .clk(clk), .rstN(rstN), .writeGateIn(writeGateIn),
    .invertPol(invertPol), .slowSel(slowSel),
    .clampOn(clampOn), .agcHold(agcHold)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setGate(input bit active);
    writeGateIn = invertPol ? ~active : active;
  endtask

  task automatic clearStats();
    idx = 0; hi = 0; first = 0; last = 0; agcBad = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idx++;
    if (clampOn === 1'b1) begin
      hi++;
      if (first == 0) first = idx;
      last = idx;
    end
    if (agcHold !== clampOn) agcBad++;
  endtask

  task automatic doReset(input bit inv);
    @(negedge clk);
    rstN = 1'b0;
    invertPol = inv;
    setGate(1'b0);
    slowSel = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs low during reset
    check(clampOn === 1'b0 && agcHold === 1'b0, "R8 reset", int'(clampOn), 0);
    rstN = 1'b1;
    clearStats();
    repeat (8) step();
    // R8: no spurious clamp after reset with idle line
    check(hi == 0, "R8 idle after reset", hi, 0);
  endtask

  // pulse of L cycles, slowSel = sa during write, sb from 4 cycles after end
  task automatic runPulse(input int L, input bit sa, input bit sb, input int expD, input string tag);
    clearStats();
    slowSel = sa;
    setGate(1'b1);
    repeat (L) step();
    setGate(1'b0);
    repeat (4) step();
    slowSel = sb;
    repeat (2 * LONG + 6) step();
    check(first == 3, {tag, " R2 latency"}, first, 3);
    check(hi == L + expD, {tag, " R3 R4 length"}, hi, L + expD);
    check(last - first + 1 == hi, {tag, " R3 contiguous"}, last - first + 1, hi);
    check(agcBad == 0, {tag, " R7 hold equals clamp"}, agcBad, 0);
    slowSel = 1'b0;
  endtask

  initial begin
    for (int inv = 0; inv < 2; inv++) begin
      doReset(bit'(inv));
      // R1 R9: sweep polarity, delay select and pulse lengths from one edge up
      for (int s = 0; s < 2; s++) begin
        for (int L = 1; L <= 6; L++) begin
          runPulse(L, bit'(s), bit'(s), s ? LONG : SHORT, $sformatf("R1 R9 inv%0d slow%0d L%0d", inv, s, L));
        end
      end
      // R5: late change of slowSel does not alter the running delay
      runPulse(3, 1'b0, 1'b1, SHORT, "R5 short then slow");
      runPulse(3, 1'b1, 1'b0, LONG, "R5 long then fast");
      // R6: re-entry at several points in the release window
      for (int g = 1; g < SHORT; g++) begin
        clearStats();
        setGate(1'b1);
        repeat (3) step();
        setGate(1'b0);
        repeat (g) step();
        setGate(1'b1);
        repeat (2) step();
        setGate(1'b0);
        repeat (2 * LONG + 6) step();
        check(hi == 3 + g + 2 + SHORT, "R6 reentry length", hi, 3 + g + 2 + SHORT);
        check(last - first + 1 == hi, "R6 no gap", last - first + 1, hi);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule